// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem control and modem status registers of a 16550-style serial port. It samples four modem input lines (clear-to-send, data-set-ready, carrier detect and ring) through a synchroniser. It records each change in a sticky delta flag, drives the four modem control outputs, and raises a change flag toward the port's interrupt logic.

Software reaches the two registers through a read strobe and a write strobe with a 3-bit offset. Control sits at offset 4 and status at offset 6. Reading the status register hands back the current line levels and the delta flags, then clears the flags. A loop-test bit in the control register stops the real control outputs and makes the status register reflect the control bits instead. This lets software exercise its modem handling without a cable.

Top module: `modem_sr`

## Requirements
- R1: After reset, status (offset 6) reads 0xB0, control (offset 4) reads 0x08, `out2_o` is high and `rts_o`, `dtr_o`, `out1_o` and `msc_o` are low.
- R2: A write to offset 4 keeps only data bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop-test). A read of offset 4 returns those bits with bits 7:5 zero. With loop-test clear, each output pin equals its control bit.
- R3: Outside loop-test, status bits 7:4 show carrier detect (7), ring (6), data-set-ready (5) and clear-to-send (4). A level change on an input pin appears there on the third rising edge after it.
- R4: A change of clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively. The bit stays set until a status read.
- R5: Status bit 2 is set only when the synchronised ring line falls from 1 to 0. A rising ring line leaves it clear.
- R6: A status read outside loop-test returns the register value, then clears bits 3:0 on that clock edge. Bits 7:4 are not affected.
- R7: `msc_o` is high exactly when any of status bits 3:0 is set and loop-test is clear.
- R8: With loop-test set, a status read returns OUT2 on bit 7, OUT1 on bit 6, DTR on bit 5 and RTS on bit 4, with bits 3:0 zero. Such a read leaves the hidden delta flags untouched, and input changes meanwhile still accumulate into them.
- R9: With loop-test set, `rts_o`, `dtr_o`, `out1_o` and `out2_o` are all low, whatever the control bits hold.
- R10: When an input change reaches the status register on the same edge as a clearing status read, the new delta bit ends up set.
- R11: Writes to offsets other than 4 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, side effects on the clock edge |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msc_o | output | 1 | Modem status change flag to the interrupt logic |

## Verification
A line change can reach the status register on the same edge as a clearing status read. That edge both loads a new delta and wipes the old ones. The bench provokes this by moving an input pin two edges before a read strobe, so the synchroniser delivers the change exactly under the strobe. A follow-up read must show the new delta and the new level, while the read under the collision returned the pre-change value. The second overlap is a read made in loop-test while a line moves. That read must show no deltas, yet the delta must still be there once loop-test is left.

// File: rtl/modem_sr_pkg.sv
package modem_sr_pkg;
    // Width of the modem line group and of the delta group
    localparam int LINE_W = 4;
    // Line positions inside the status upper nibble (and delta lower nibble)
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    // Control register field positions
    localparam int CTL_W    = 5;
    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_OUT1  = 2;
    localparam int CB_OUT2  = 3;
    localparam int CB_LOOP  = 4;
    // Reset values: carrier, data-set-ready and clear-to-send high; OUT2 set
    localparam logic [LINE_W-1:0] LINE_RST = 4'b1011;
    localparam logic [CTL_W-1:0]  CTL_RST  = 5'b01000;
endpackage

// File: rtl/msr_sync.sv
// Multi-stage synchroniser for a group of asynchronous level inputs.
// Assumes inputs are slow levels; each bit is synchronised on its own.
// Stages reset to RST_VAL so no false change is seen after reset.
module msr_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Pass the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
// Holds the registered line levels and the sticky delta flags.
// Non-ring deltas set on any change (old XOR new); the ring delta sets
// only on a 1->0 transition. A clearing read wipes old deltas but a
// change landing on the same edge still sets its flag.
module msr_delta
    import modem_sr_pkg::*;
#(
    parameter int W = LINE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_new,
    input  logic         rd_clr,
    output logic [W-1:0] lines_q,
    output logic [W-1:0] delta_q
);
    logic [W-1:0] set_vec;

    for (genvar i = 0; i < W; i++) begin : g_set
        if (i == LN_RI) begin : g_fall
            // Trailing-edge detect for the ring line
            assign set_vec[i] = lines_q[i] & ~lines_new[i];
        end else begin : g_any
            // Any-edge detect for the other lines
            assign set_vec[i] = lines_q[i] ^ lines_new[i];
        end
    end

    // Register the current line levels
    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= LINE_RST;
        else        lines_q <= lines_new;
    end

    // Accumulate delta flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) delta_q <= '0;
        else        delta_q <= (rd_clr ? '0 : delta_q) | set_vec;
    end

    AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_vec == '0) |=> (delta_q == '0)); // R6
    AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_RI]) |-> ($past(lines_q[LN_RI]) && !lines_q[LN_RI])); // R5
    AST_CTS_DELTA_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_CTS]) |-> (lines_q[LN_CTS] != $past(lines_q[LN_CTS]))); // R4
    AST_NEW_DELTA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_vec != '0) |=> (delta_q != '0)); // R10
endmodule

// File: rtl/mcr_reg.sv
// Modem control register and its output pins.
// Keeps five bits; pins are forced low while the loop-test bit is set.
module mcr_reg
    import modem_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wbits,
    output logic [CTL_W-1:0] ctl_q,
    output logic             rts_o,
    output logic             dtr_o,
    output logic             out1_o,
    output logic             out2_o
);
    logic loop_on;

    // Store the control bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= CTL_RST;
        else if (wr) ctl_q <= wbits;
    end

    assign loop_on = ctl_q[CB_LOOP];
    assign rts_o   = ctl_q[CB_RTS]  & ~loop_on;
    assign dtr_o   = ctl_q[CB_DTR]  & ~loop_on;
    assign out1_o  = ctl_q[CB_OUT1] & ~loop_on;
    assign out2_o  = ctl_q[CB_OUT2] & ~loop_on;
endmodule

// File: rtl/modem_sr.sv
// Top of the modem control/status register pair.
// Decodes the register offsets, builds the status read value (live or
// loop-test remap) and the status-change flag. Assumes one access per
// cycle; rdata is valid combinationally for the presented address.
module modem_sr
    import modem_sr_pkg::*;
#(
    parameter int               ADDR_W     = 3,
    parameter int               SYNC_STG   = 2,
    parameter logic [ADDR_W-1:0] CTL_OFS   = 3'd4,
    parameter logic [ADDR_W-1:0] STS_OFS   = 3'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              dcd_i,
    input  logic              ri_i,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              out1_o,
    output logic              out2_o,
    output logic              msc_o
);
    logic [LINE_W-1:0] pins_raw, pins_sync, lines_q, delta_q, loop_lines;
    logic [CTL_W-1:0]  ctl_q;
    logic              loop_on, rd_clr, ctl_wr;
    logic [7:0]        sts_val;
    logic [7-CTL_W:0]  unused_wdata_hi;

    assign unused_wdata_hi = wdata[7:CTL_W];

    assign pins_raw[LN_CTS] = cts_i;
    assign pins_raw[LN_DSR] = dsr_i;
    assign pins_raw[LN_RI]  = ri_i;
    assign pins_raw[LN_DCD] = dcd_i;

    msr_sync #(.W(LINE_W), .STAGES(SYNC_STG), .RST_VAL(LINE_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync)
    );

    assign ctl_wr  = wr_en && (addr == CTL_OFS);
    assign loop_on = ctl_q[CB_LOOP];
    assign rd_clr  = rd_en && (addr == STS_OFS) && !loop_on;

    msr_delta #(.W(LINE_W)) u_delta (
        .clk(clk), .rst_n(rst_n), .lines_new(pins_sync), .rd_clr(rd_clr),
        .lines_q(lines_q), .delta_q(delta_q)
    );

    mcr_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wbits(wdata[CTL_W-1:0]),
        .ctl_q(ctl_q), .rts_o(rts_o), .dtr_o(dtr_o),
        .out1_o(out1_o), .out2_o(out2_o)
    );

    // Loop-test remap of control bits onto the line positions
    always_comb begin
        loop_lines          = '0;
        loop_lines[LN_DCD]  = ctl_q[CB_OUT2];
        loop_lines[LN_RI]   = ctl_q[CB_OUT1];
        loop_lines[LN_DSR]  = ctl_q[CB_DTR];
        loop_lines[LN_CTS]  = ctl_q[CB_RTS];
    end

    // Status view: live lines and deltas, or the remap with deltas hidden
    assign sts_val = loop_on ? {loop_lines, {LINE_W{1'b0}}} : {lines_q, delta_q};

    // Read data multiplexer
    always_comb begin
        if (addr == CTL_OFS)      rdata = {{(8-CTL_W){1'b0}}, ctl_q};
        else if (addr == STS_OFS) rdata = sts_val;
        else                      rdata = 8'h00;
    end

    assign msc_o = (|delta_q) && !loop_on;

    AST_PINS_QUIET_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> !(rts_o || dtr_o || out1_o || out2_o)); // R9
    AST_FLAG_NOT_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        msc_o |-> !loop_on); // R7
    AST_LOOP_READ_KEEPS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STS_OFS && loop_on && delta_q != '0) |=> (delta_q != '0)); // R8
    AST_CTL_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_q == $past(wdata[CTL_W-1:0]))); // R2
endmodule

// File: tb/modem_sr_test.sv
module modem_sr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
    logic       rts_o, dtr_o, out1_o, out2_o, msc_o;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    modem_sr uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cts_i(cts_i), .dsr_i(dsr_i),
        .dcd_i(dcd_i), .ri_i(ri_i), .rts_o(rts_o), .dtr_o(dtr_o),
        .out1_o(out1_o), .out2_o(out2_o), .msc_o(msc_o)
    );

    // Vector: {lines dcd,ri,dsr,cts ; expected status read}
    localparam logic [11:0] VEC [8] = '{
        {4'b1010, 8'hA1},   // R4 clear-to-send drops
        {4'b1110, 8'hE0},   // R5 ring rises, no trailing flag
        {4'b1010, 8'hA4},   // R5 ring falls
        {4'b0011, 8'h39},   // R4 carrier drops, clear-to-send rises
        {4'b0001, 8'h12},   // R4 data-set-ready drops
        {4'b1111, 8'hFA},   // R4 carrier, dsr change; ring rises
        {4'b1011, 8'hB4},   // R5 ring falls again
        {4'b1011, 8'hB0}    // R6 no change, nothing sticky
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [3:0] l);
        {dcd_i, ri_i, dsr_i, cts_i} = l;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read with side effects: sample before the edge that applies them
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd(3'd6, v); chk("R1 status", v, 8'hB0);
        rd(3'd4, v); chk("R1 control", v, 8'h08);
        #1 chk("R1 pins", {3'b0, msc_o, rts_o, dtr_o, out1_o, out2_o}, 8'h01);

        // Vector walk: R3 R4 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) set_lines(VEC[k][11:8]);
            repeat (4) @(negedge clk);
            #1 chk("R7 flag", {7'b0, msc_o}, {7'b0, |VEC[k][3:0]});
            rd(3'd6, v); chk("R3/R4/R5 status", v, VEC[k][7:0]);
            rd(3'd6, v); chk("R6 cleared", v, {VEC[k][7:4], 4'h0});
        end

        // R2 control width and pin mapping
        wr(3'd4, 8'h0F);
        rd(3'd4, v); chk("R2 read 0F", v, 8'h0F);
        #1 chk("R2 pins all", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h0F);
        wr(3'd4, 8'hE5);
        rd(3'd4, v); chk("R2 upper bits dropped", v, 8'h05);
        #1 chk("R2 pins dtr out1", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h06);

        // R11 other offsets
        wr(3'd7, 8'h1F);
        rd(3'd4, v); chk("R11 control unchanged", v, 8'h05);
        rd(3'd2, v); chk("R11 read other", v, 8'h00);

        // R8 R9 loop-test: loop + RTS + OUT2
        wr(3'd4, 8'h1A);
        #1 chk("R9 pins quiet", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h00);
        rd(3'd6, v); chk("R8 loop remap", v, 8'h90);
        wr(3'd4, 8'h15);   // loop + DTR + OUT1
        rd(3'd6, v); chk("R8 loop remap 2", v, 8'h60);
        @(negedge clk) set_lines(4'b1010);
        repeat (4) @(negedge clk);
        rd(3'd6, v); chk("R8 deltas hidden", v, 8'h60);
        #1 chk("R7 flag off in loop", {7'b0, msc_o}, 8'h00);
        wr(3'd4, 8'h08);
        rd(3'd6, v); chk("R8 delta kept", v, 8'hA1);

        // R10 change lands on the clearing read edge
        @(negedge clk) set_lines(4'b1011);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 3'd6; rd_en = 1'b1;
        #2 v = rdata;
        @(negedge clk) rd_en = 1'b0;
        chk("R10 pre-change value", v, 8'hA0);
        rd(3'd6, v); chk("R10 new delta kept", v, 8'hB1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule